// File: doc/BRIEF.md
# Address Window Access Guard

The guard checks every bus access against six programmable address windows. Each window spans a power-of-two number of bytes, from 512 bytes up to 2 MB. Each window is aligned to its own size. A privilege register sets the rules:

- a read enable and a write enable for each window;
- a global read enable and a global write enable, used for addresses that fall in no window;
- a test bit;
- a master enable bit.

An access that breaks the rules is refused through a deny output in the same cycle. The breach is also recorded at the next clock edge. A read breach and a write breach each have a sticky flag of their own. The address of the first breach is captured and held until software clears the flags.

Software programs the block through a simple write port:

- selectors 0 to 5 load the window registers;
- selector 6 loads the privilege register;
- selector 7 raises fault flags on purpose, to test the path downstream;
- selector 8 clears the flags.

In test mode, breaches are still flagged and recorded, but no access is refused. This lets a rule set be tried on live traffic.

Top module: `addr_guard`

## Requirements
- R1: After a synchronous reset every register is zero. The unit is then disabled, acc_deny is 0, rd_fault and wr_fault are 0, and fault_addr is 0.
- R2: A write with cfg_sel 0..5 loads window 0..5. The base address is taken from cfg_wdata[31:9] and the size code from cfg_wdata[4:0]. An address hits the window when its bits above the size code equal the same bits of the base, so the window spans 2^code bytes.
- R3: A window whose size code lies outside 9..21 never hits.
- R4: A write with cfg_sel 6 loads the privilege register with this layout: bits 0..5 are the window write enables, bits 10..15 the window read enables, bit 9 the global write enable, bit 19 the global read enable, bit 30 the test bit and bit 31 the unit enable. An access that hits one or more windows is allowed if any hit window grants its direction, and the global bits are then not consulted.
- R5: An access that hits no window is allowed only if the global bit for its direction (acc_write=1 for write) is set.
- R6: acc_deny is combinational. It is 1 in the same cycle as an access with acc_valid=1 when the unit is enabled, the access is not allowed and the test bit is clear. It is 0 whenever acc_valid is 0.
- R7: A refused access sets rd_fault (read) or wr_fault (write) at the next clock edge. The flag stays set until it is cleared.
- R8: fault_addr takes the address of a refused access only if neither flag is set at that edge; otherwise it holds its value.
- R9: A write with cfg_sel 8 clears rd_fault when cfg_wdata[0] is 1 and wr_fault when cfg_wdata[1] is 1. A breach in the same cycle sets its flag anyway.
- R10: With the enable bit clear, no access is refused and no flag is raised.
- R11: With the test bit set, breaches set the flags and capture the address, but acc_deny stays 0.
- R12: A write with cfg_sel 7 sets rd_fault when cfg_wdata[0] is 1 and wr_fault when cfg_wdata[1] is 1. It leaves fault_addr unchanged.
- R13: With the enable bit set and every permission bit zero, every valid access is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target selector |
| cfg_wdata | input | 32 | Configuration write data |
| acc_deny | output | 1 | Access refused (combinational) |
| rd_fault | output | 1 | Sticky read breach flag |
| wr_fault | output | 1 | Sticky write breach flag |
| fault_addr | output | 32 | Address of the first recorded breach |

## Verification
A table of addresses is run against one fixed set of windows, and each entry separates one rule:

- **Overlapping windows** where only one window grants the direction show that any granting hit is enough.
- **Bytes just inside and just past a window edge**, at the smallest and the largest size, show the mask width.
- **An address inside a window that lacks the right** shows that a hit overrides the global bits.
- **Windows with out-of-range size codes** show that such windows fall through to the global rules.

Directed sequences then separate the flag and capture rules:

- the first breach against a later one;
- clearing one flag against clearing both;
- a refused access against a forced flag;
- test mode against a disabled unit;
- an all-zero privilege word.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int WIN_COUNT = 6;
    localparam int CODE_W    = 5;
    localparam int BASE_LSB  = 9;
    localparam int MIN_CODE  = 9;
    localparam int MAX_CODE  = 21;
    localparam int SEL_W     = 4;

    // privilege word bit positions
    localparam int WR_LSB    = 0;
    localparam int GWR_BIT   = 9;
    localparam int RD_LSB    = 10;
    localparam int GRD_BIT   = 19;
    localparam int TEST_BIT  = 30;
    localparam int EN_BIT    = 31;

    // selector values
    localparam logic [SEL_W-1:0] SEL_PRIV   = SEL_W'(WIN_COUNT);
    localparam logic [SEL_W-1:0] SEL_INJECT = SEL_W'(WIN_COUNT + 1);
    localparam logic [SEL_W-1:0] SEL_CLEAR  = SEL_W'(WIN_COUNT + 2);

    typedef struct packed {
        logic [ADDR_W-1:BASE_LSB] base;
        logic [CODE_W-1:0]        code;
    } window_t;

    typedef struct packed {
        logic                 en;
        logic                 test;
        logic                 g_rd;
        logic                 g_wr;
        logic [WIN_COUNT-1:0] rd;
        logic [WIN_COUNT-1:0] wr;
    } perm_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } flag_pair_t;

    function automatic window_t unpack_window(input logic [DATA_W-1:0] w);
        window_t r;
        r.base = w[ADDR_W-1:BASE_LSB];
        r.code = w[CODE_W-1:0];
        return r;
    endfunction

    function automatic perm_t unpack_perm(input logic [DATA_W-1:0] w);
        perm_t r;
        r.en   = w[EN_BIT];
        r.test = w[TEST_BIT];
        r.g_rd = w[GRD_BIT];
        r.g_wr = w[GWR_BIT];
        r.rd   = w[RD_LSB +: WIN_COUNT];
        r.wr   = w[WR_LSB +: WIN_COUNT];
        return r;
    endfunction

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        return (c >= CODE_W'(MIN_CODE)) && (c <= CODE_W'(MAX_CODE));
    endfunction

endpackage

// File: rtl/ag_cfg_regs.sv
module ag_cfg_regs
    import addr_guard_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [DATA_W-1:0]       cfg_wdata,
    output window_t                 win [WIN_COUNT],
    output perm_t                   perm,
    output flag_pair_t              inject,
    output flag_pair_t              clear
);

    for (genvar g = 0; g < WIN_COUNT; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst)
                win[g] <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(g))
                win[g] <= unpack_window(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            perm <= '0;
        else if (cfg_we && cfg_sel == SEL_PRIV)
            perm <= unpack_perm(cfg_wdata);
    end

    always_comb begin
        inject = '0;
        clear  = '0;
        if (cfg_we && cfg_sel == SEL_INJECT) begin
            inject.rd = cfg_wdata[0];
            inject.wr = cfg_wdata[1];
        end
        if (cfg_we && cfg_sel == SEL_CLEAR) begin
            clear.rd = cfg_wdata[0];
            clear.wr = cfg_wdata[1];
        end
    end

endmodule

// File: rtl/ag_window_match.sv
module ag_window_match
    import addr_guard_pkg::*;
(
    input  window_t           win,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] keep_mask;

    always_comb begin
        base_full = {win.base, {BASE_LSB{1'b0}}};
        keep_mask = {ADDR_W{1'b1}} << win.code;
        hit = code_ok(win.code) && (((addr ^ base_full) & keep_mask) == '0);
    end

endmodule

// File: rtl/ag_decide.sv
module ag_decide
    import addr_guard_pkg::*;
(
    input  perm_t                 perm,
    input  logic [WIN_COUNT-1:0]  hits,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    output logic                  breach,
    output logic                  deny
);

    logic [WIN_COUNT-1:0] grant;
    logic                 fallback;
    logic                 allowed;

    always_comb begin
        grant    = hits & (acc_write ? perm.wr : perm.rd);
        fallback = acc_write ? perm.g_wr : perm.g_rd;
        allowed  = (|hits) ? (|grant) : fallback;
        breach   = acc_valid && perm.en && !allowed;
        deny     = breach && !perm.test;
    end

endmodule

// File: rtl/ag_fault_log.sv
module ag_fault_log
    import addr_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              breach,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  flag_pair_t        inject,
    input  flag_pair_t        clear,
    output flag_pair_t        flags,
    output logic [ADDR_W-1:0] addr_q
);

    flag_pair_t set_now;

    always_comb begin
        set_now.rd = (breach && !acc_write) || inject.rd;
        set_now.wr = (breach &&  acc_write) || inject.wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            addr_q <= '0;
        end else begin
            flags.rd <= set_now.rd || (flags.rd && !clear.rd);
            flags.wr <= set_now.wr || (flags.wr && !clear.wr);
            if (breach && !flags.rd && !flags.wr)
                addr_q <= acc_addr;
        end
    end

    // R7: a set flag survives any cycle without a clear for it
    a_r7_rd_sticky: assert property (@(posedge clk) disable iff (rst)
        flags.rd && !clear.rd |=> flags.rd);
    a_r7_wr_sticky: assert property (@(posedge clk) disable iff (rst)
        flags.wr && !clear.wr |=> flags.wr);
    // R8: captured address frozen while a flag is pending
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (flags.rd || flags.wr) |=> $stable(addr_q));
    // R12: forcing a flag alone does not move the address
    a_r12_inject_no_capture: assert property (@(posedge clk) disable iff (rst)
        !breach |=> $stable(addr_q));

endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import addr_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              acc_deny,
    output logic              rd_fault,
    output logic              wr_fault,
    output logic [31:0]       fault_addr
);

    window_t              win [WIN_COUNT];
    perm_t                perm;
    flag_pair_t           inject;
    flag_pair_t           clear;
    flag_pair_t           flags;
    logic [WIN_COUNT-1:0] hits;
    logic                 breach;

    ag_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win       (win),
        .perm      (perm),
        .inject    (inject),
        .clear     (clear)
    );

    for (genvar g = 0; g < WIN_COUNT; g++) begin : g_match
        ag_window_match u_match (
            .win  (win[g]),
            .addr (acc_addr),
            .hit  (hits[g])
        );
    end

    ag_decide u_decide (
        .perm      (perm),
        .hits      (hits),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .breach    (breach),
        .deny      (acc_deny)
    );

    ag_fault_log u_log (
        .clk       (clk),
        .rst       (rst),
        .breach    (breach),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .inject    (inject),
        .clear     (clear),
        .flags     (flags),
        .addr_q    (fault_addr)
    );

    assign rd_fault = flags.rd;
    assign wr_fault = flags.wr;

    // R6: no refusal without an access
    a_r6_deny_needs_valid: assert property (@(posedge clk) disable iff (rst)
        acc_deny |-> acc_valid);
    // R11: test mode never refuses
    a_r11_test_no_deny: assert property (@(posedge clk) disable iff (rst)
        perm.test |-> !acc_deny);
    // R10: disabled unit neither refuses nor raises a flag on its own
    a_r10_off_no_deny: assert property (@(posedge clk) disable iff (rst)
        !perm.en |-> !acc_deny);
    a_r10_off_no_flag: assert property (@(posedge clk) disable iff (rst)
        !perm.en && !rd_fault && !inject.rd |=> !rd_fault);

endmodule

// File: tb/test_addr_guard.sv
module test_addr_guard;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        acc_write;
    logic        cfg_we;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        acc_deny;
    logic        rd_fault;
    logic        wr_fault;
    logic [31:0] fault_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    addr_guard i_addr_guard (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_deny(acc_deny), .rd_fault(rd_fault),
        .wr_fault(wr_fault), .fault_addr(fault_addr)
    );

    localparam logic [31:0] PRIV_STD = 32'h8008_541E;

    // {address, write, expected deny}
    localparam logic [33:0] VEC [0:13] = '{
        {32'h0001_0000, 1'b0, 1'b0},  // R2 window0 read ok
        {32'h0001_0FFF, 1'b0, 1'b0},  // R2 last byte of window0
        {32'h0001_1000, 1'b0, 1'b1},  // R4 only window3 (no read)
        {32'h0001_0100, 1'b1, 1'b0},  // R4 window3 grants write
        {32'h0002_0000, 1'b1, 1'b0},  // R2 512B window
        {32'h0002_01FF, 1'b1, 1'b0},  // R2 edge of 512B window
        {32'h0002_0200, 1'b1, 1'b1},  // R5 no window, global write off
        {32'h0002_0200, 1'b0, 1'b0},  // R5 global read on
        {32'h0002_0000, 1'b0, 1'b1},  // R4 hit overrides global read
        {32'h0020_0000, 1'b1, 1'b0},  // R2 2MB window start
        {32'h003F_FFFF, 1'b0, 1'b0},  // R2 2MB window end
        {32'h0040_0000, 1'b1, 1'b1},  // R5 past 2MB window
        {32'h0005_0000, 1'b1, 1'b1},  // R3 code 8 never hits
        {32'h0060_0000, 1'b0, 1'b0}   // R3 code 22 never hits
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // presents one access for one cycle; returns deny seen mid-cycle
    task automatic access(input logic [31:0] a, input logic w, output logic d);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        #1 d = acc_deny;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic d;
        rst = 1'b1; acc_valid = 0; acc_addr = 0; acc_write = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 flags", {30'd0, rd_fault, wr_fault}, 32'd0);
        check("R1 fault_addr", fault_addr, 32'd0);
        access(32'h0040_0000, 1'b1, d);
        check("R1 R10 disabled deny", {31'd0, d}, 32'd0);
        check("R10 no flag when off", {30'd0, rd_fault, wr_fault}, 32'd0);

        cfg(4'd0, 32'h0001_000C);
        cfg(4'd1, 32'h0002_0009);
        cfg(4'd2, 32'h0020_0015);
        cfg(4'd3, 32'h0001_0010);
        cfg(4'd4, 32'h0005_0008);
        cfg(4'd5, 32'h0060_0016);
        cfg(4'd6, PRIV_STD);

        for (int i = 0; i < 14; i++) begin
            access(VEC[i][33:2], VEC[i][1], d);
            check($sformatf("R2-table vec %0d", i), {31'd0, d}, {31'd0, VEC[i][0]});
        end
        cfg(4'd8, 32'h3);
        check("R9 clear both", {30'd0, rd_fault, wr_fault}, 32'd0);

        // R6: valid low never denies
        @(negedge clk);
        acc_valid = 0; acc_addr = 32'h0040_0000; acc_write = 1;
        #1 check("R6 no valid", {31'd0, acc_deny}, 32'd0);
        @(negedge clk);
        check("R6 no valid no flag", {30'd0, rd_fault, wr_fault}, 32'd0);

        // R7/R8 capture
        access(32'h0002_0200, 1'b1, d);
        check("R7 wr flag", {30'd0, rd_fault, wr_fault}, 32'd1);
        check("R8 capture", fault_addr, 32'h0002_0200);
        access(32'h0002_0000, 1'b0, d);
        check("R7 rd flag", {30'd0, rd_fault, wr_fault}, 32'd3);
        check("R8 hold", fault_addr, 32'h0002_0200);
        cfg(4'd8, 32'h2);
        check("R9 clear wr only", {30'd0, rd_fault, wr_fault}, 32'd2);
        cfg(4'd8, 32'h1);
        check("R9 clear rd", {30'd0, rd_fault, wr_fault}, 32'd0);
        access(32'h0040_0000, 1'b1, d);
        check("R8 new capture", fault_addr, 32'h0040_0000);

        // R9 breach wins over clear in same cycle
        @(negedge clk);
        cfg_we = 1; cfg_sel = 4'd8; cfg_wdata = 32'h3;
        acc_valid = 1; acc_addr = 32'h0002_0200; acc_write = 1;
        @(negedge clk);
        cfg_we = 0; acc_valid = 0;
        check("R9 set wins", {30'd0, rd_fault, wr_fault}, 32'd1);
        cfg(4'd8, 32'h3);

        // R11 test mode
        cfg(4'd6, PRIV_STD | 32'h4000_0000);
        access(32'h0040_0000, 1'b1, d);
        check("R11 no deny", {31'd0, d}, 32'd0);
        check("R11 flag", {30'd0, rd_fault, wr_fault}, 32'd1);
        check("R11 capture", fault_addr, 32'h0040_0000);
        cfg(4'd8, 32'h3);

        // R12 inject
        cfg(4'd7, 32'h1);
        check("R12 inject rd", {30'd0, rd_fault, wr_fault}, 32'd2);
        check("R12 addr kept", fault_addr, 32'h0040_0000);
        cfg(4'd8, 32'h3);

        // R10 disabled after programming
        cfg(4'd6, PRIV_STD & 32'h7FFF_FFFF);
        access(32'h0040_0000, 1'b1, d);
        check("R10 off deny", {31'd0, d}, 32'd0);
        check("R10 off flag", {30'd0, rd_fault, wr_fault}, 32'd0);

        // R13 no-access word
        cfg(4'd6, 32'h8000_0000);
        access(32'h0001_0000, 1'b0, d);
        check("R13 read denied", {31'd0, d}, 32'd1);
        access(32'h0020_0000, 1'b1, d);
        check("R13 write denied", {31'd0, d}, 32'd1);

        finish_run();
    end

endmodule